// File: doc/BRIEF.md
# Interrupt Mask and Autovector Controller

The controller gathers seven external request levels (1 to 7) and a parameterised set of internal interrupt sources. Each source has a pending bit and a mask bit. A pending bit follows its source one clock later and is set whether or not the source is masked. The priority output carries the highest level among the sources that are pending and not masked. It is 0 when no such source exists.

When the core acknowledges a level, the block answers on the next clock. It either generates the autovector itself or tells the external device to drive the vector. The choice is made per level by an autovector control register, and that register only applies to levels that the level-enable input has enabled. Bit 0 of the same register blocks the address strobe during autovector acknowledges. A small register bus reads the pending register and reads and writes the mask and autovector registers.

Top module: `irq_avec_ctrl`

## Requirements
- R1: After reset every source is masked: the mask reads all ones except bit 0, which reads 0. The autovector register reads 0, the priority output is 0 and no acknowledge response is given.
- R2: The pending register (bus address 0) shows the external level n at bit n as request AND level-enable. It shows internal source k at bit 8+k. Each bit follows its input one clock after the input is sampled, whatever the mask holds.
- R3: A bus write to address 0 leaves the pending register unchanged.
- R4: The priority output equals the highest level among the sources that are both pending and unmasked, and is 0 when there is none. External source n has level n, and internal source k has level (k mod 7)+1.
- R5: A bus write to address 1 loads the mask register, where a 1 masks the source and a 0 enables it. The new value reads back, and bit 0 always reads 0.
- R6: A bus write to address 2 loads the 8-bit autovector register. Bits 7 to 1 select autovectoring for levels 7 to 1, and bit 0 is the block bit. The written value reads back.
- R7: An acknowledge of level L (1 to 7) gives a valid response one clock later. The response is an autovector when autovector bit L and level-enable L are both 1, and then the vector number is 24+L (offset 0x64+4(L-1), divided by 4). Otherwise the response carries the external-vector flag and vector number 0.
- R8: The address-strobe block output is 1 exactly when the response is an autovector and the block bit is 1.
- R9: The response is valid only in the cycle after a cycle in which the acknowledge input is high. An acknowledge of level 0 gives no response.
- R10: An acknowledge in the same cycle as a write to the autovector register is answered with the register value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| ext_irq_i | input | 7 | External level requests, bit n = level n |
| lvl_en_i | input | 7 | Level enable for each external level |
| int_irq_i | input | N_INT | Internal interrupt sources |
| ipl_o | output | 3 | Highest pending unmasked level, 0 = none |
| reg_addr_i | input | 2 | Register address: 0 pending, 1 mask, 2 autovector |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | REG_W | Write data |
| reg_rdata_o | output | REG_W | Read data for reg_addr_i |
| iack_i | input | 1 | Interrupt acknowledge strobe |
| iack_lvl_i | input | 3 | Level being acknowledged |
| ack_vld_o | output | 1 | Acknowledge response valid |
| ack_auto_o | output | 1 | Response is an internally generated autovector |
| ack_ext_o | output | 1 | External device must drive the vector |
| ack_vec_o | output | 8 | Autovector number |
| as_block_o | output | 1 | Suppress the address strobe for this acknowledge |

## Verification
Two things can land in the same cycle: a bus write to the autovector register and an acknowledge. The bench first clears the register. It then raises an acknowledge in the cycle that writes all ones, and expects the external-vector answer from the old value. A second acknowledge must then see the new value. Mask writes also share cycles with source changes across a long pseudo-random sweep, and the priority output is compared with a value computed from the mask that is current once the write has taken effect.

// File: rtl/irq_avec_pkg.sv
package irq_avec_pkg;

    localparam int EXT_LVLS = 7;
    localparam int VEC_BASE = 24;

    typedef enum logic [1:0] {
        REG_PEND = 2'd0,
        REG_MASK = 2'd1,
        REG_AVEC = 2'd2,
        REG_NONE = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic       vld;
        logic       auto_v;
        logic       ext;
        logic [7:0] vec;
        logic       blk;
    } ack_resp_t;

    function automatic logic [2:0] int_src_level(int k);
        return 3'((k % EXT_LVLS) + 1);
    endfunction

endpackage

// File: rtl/irq_pend_mask.sv
module irq_pend_mask #(
    parameter int N_INT = 8,
    parameter int REG_W = 8 + N_INT
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [7:1]       ext_irq_i,
    input  logic [7:1]       lvl_en_i,
    input  logic [N_INT-1:0] int_irq_i,
    input  logic             wr_mask_i,
    input  logic [REG_W-1:0] wdata_i,
    output logic [REG_W-1:0] pend_o,
    output logic [REG_W-1:0] mask_o
);
    localparam logic [REG_W-1:0] MASK_RST = ~REG_W'(1);

    typedef struct packed {
        logic [REG_W-1:0] pend;
        logic [REG_W-1:0] mask;
    } pm_state_t;

    pm_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.pend = '0;
        st_d.pend[7:1] = ext_irq_i & lvl_en_i;
        st_d.pend[REG_W-1:8] = int_irq_i;
        if (wr_mask_i) begin
            st_d.mask = wdata_i;
            st_d.mask[0] = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.pend <= '0;
            st_q.mask <= MASK_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o = st_q.pend;
    assign mask_o = st_q.mask;
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int N_INT = 8,
    parameter int REG_W = 8 + N_INT
) (
    input  logic [REG_W-1:0] pend_i,
    input  logic [REG_W-1:0] mask_i,
    output logic [2:0]       ipl_o
);
    import irq_avec_pkg::*;

    function automatic logic [REG_W-1:0] lvl_sel(int lvl);
        logic [REG_W-1:0] s;
        s = '0;
        s[lvl] = 1'b1;
        for (int k = 0; k < N_INT; k++) begin
            if (int'(int_src_level(k)) == lvl) s[8+k] = 1'b1;
        end
        return s;
    endfunction

    logic [REG_W-1:0] active;
    logic [7:1]       hit;

    assign active = pend_i & ~mask_i;

    for (genvar l = 1; l <= EXT_LVLS; l++) begin : g_lvl
        localparam logic [REG_W-1:0] SEL = lvl_sel(l);
        assign hit[l] = |(active & SEL);
    end

    always_comb begin
        ipl_o = 3'd0;
        for (int l = 1; l <= EXT_LVLS; l++) begin
            if (hit[l]) ipl_o = 3'(l);
        end
    end
endmodule

// File: rtl/irq_ack_resp.sv
module irq_ack_resp (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    wr_avec_i,
    input  logic [7:0]              wdata_i,
    input  logic [7:1]              lvl_en_i,
    input  logic                    iack_i,
    input  logic [2:0]              iack_lvl_i,
    output logic [7:0]              avec_o,
    output irq_avec_pkg::ack_resp_t resp_o
);
    import irq_avec_pkg::*;

    typedef struct packed {
        logic [7:0] avec;
        ack_resp_t  resp;
    } ar_state_t;

    ar_state_t  st_d, st_q;
    logic [7:0] en_full;
    logic       use_auto;

    assign en_full  = {lvl_en_i, 1'b0};
    assign use_auto = st_q.avec[iack_lvl_i] & en_full[iack_lvl_i];

    always_comb begin
        st_d = st_q;
        st_d.resp = '0;
        if (wr_avec_i) st_d.avec = wdata_i;
        if (iack_i && (iack_lvl_i != 3'd0)) begin
            st_d.resp.vld    = 1'b1;
            st_d.resp.auto_v = use_auto;
            st_d.resp.ext    = ~use_auto;
            st_d.resp.vec    = use_auto ? 8'(VEC_BASE + int'(iack_lvl_i)) : 8'd0;
            st_d.resp.blk    = use_auto & st_q.avec[0];
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign avec_o = st_q.avec;
    assign resp_o = st_q.resp;
endmodule

// File: rtl/irq_avec_ctrl.sv
module irq_avec_ctrl #(
    parameter  int N_INT = 8,
    localparam int REG_W = 8 + N_INT
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [7:1]       ext_irq_i,
    input  logic [7:1]       lvl_en_i,
    input  logic [N_INT-1:0] int_irq_i,
    output logic [2:0]       ipl_o,
    input  logic [1:0]       reg_addr_i,
    input  logic             reg_wr_i,
    input  logic [REG_W-1:0] reg_wdata_i,
    output logic [REG_W-1:0] reg_rdata_o,
    input  logic             iack_i,
    input  logic [2:0]       iack_lvl_i,
    output logic             ack_vld_o,
    output logic             ack_auto_o,
    output logic             ack_ext_o,
    output logic [7:0]       ack_vec_o,
    output logic             as_block_o
);
    import irq_avec_pkg::*;

    logic [REG_W-1:0] pend_w, mask_w;
    logic [7:0]       avec_w;
    ack_resp_t        resp_w;
    reg_addr_e        addr;

    assign addr = reg_addr_e'(reg_addr_i);

    irq_pend_mask #(.N_INT(N_INT), .REG_W(REG_W)) i_pend_mask (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .ext_irq_i (ext_irq_i),
        .lvl_en_i  (lvl_en_i),
        .int_irq_i (int_irq_i),
        .wr_mask_i (reg_wr_i && addr == REG_MASK),
        .wdata_i   (reg_wdata_i),
        .pend_o    (pend_w),
        .mask_o    (mask_w)
    );

    irq_prio_enc #(.N_INT(N_INT), .REG_W(REG_W)) i_prio_enc (
        .pend_i (pend_w),
        .mask_i (mask_w),
        .ipl_o  (ipl_o)
    );

    irq_ack_resp i_ack_resp (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_avec_i  (reg_wr_i && addr == REG_AVEC),
        .wdata_i    (reg_wdata_i[7:0]),
        .lvl_en_i   (lvl_en_i),
        .iack_i     (iack_i),
        .iack_lvl_i (iack_lvl_i),
        .avec_o     (avec_w),
        .resp_o     (resp_w)
    );

    always_comb begin
        case (addr)
            REG_PEND: reg_rdata_o = pend_w;
            REG_MASK: reg_rdata_o = mask_w;
            REG_AVEC: reg_rdata_o = REG_W'(avec_w);
            default:  reg_rdata_o = '0;
        endcase
    end

    assign ack_vld_o  = resp_w.vld;
    assign ack_auto_o = resp_w.auto_v;
    assign ack_ext_o  = resp_w.ext;
    assign ack_vec_o  = resp_w.vec;
    assign as_block_o = resp_w.blk;
endmodule

// File: rtl/irq_avec_chk.sv
module irq_avec_chk #(
    parameter int REG_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [7:1]       ext_irq,
    input logic [7:1]       lvl_en,
    input logic             iack,
    input logic [2:0]       iack_lvl,
    input logic [2:0]       ipl,
    input logic [REG_W-1:0] pend,
    input logic [REG_W-1:0] mask,
    input logic             ack_vld,
    input logic             ack_auto,
    input logic             ack_ext,
    input logic [7:0]       ack_vec,
    input logic             as_block
);
    assert_pend_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> pend[7:1] == $past(ext_irq & lvl_en));

    assert_ipl_needs_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ipl != 3'd0) |-> (|(pend & ~mask)));

    assert_ipl_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & ~mask) == '0) |-> (ipl == 3'd0));

    assert_mask_bit0_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mask[0] == 1'b0);

    assert_resp_kind_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ack_vld |-> $onehot({ack_auto, ack_ext}));

    assert_auto_vec_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ack_auto |-> (ack_vec == 8'(24 + int'($past(iack_lvl)))));

    assert_block_auto_R8: assert property (@(posedge clk) disable iff (!rst_n)
        as_block |-> ack_auto);

    assert_resp_after_iack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(iack && iack_lvl != 3'd0) |=> !ack_vld);
endmodule

bind irq_avec_ctrl irq_avec_chk #(.REG_W(REG_W)) i_chk (
    .clk      (clk_i),
    .rst_n    (rst_ni),
    .ext_irq  (ext_irq_i),
    .lvl_en   (lvl_en_i),
    .iack     (iack_i),
    .iack_lvl (iack_lvl_i),
    .ipl      (ipl_o),
    .pend     (pend_w),
    .mask     (mask_w),
    .ack_vld  (ack_vld_o),
    .ack_auto (ack_auto_o),
    .ack_ext  (ack_ext_o),
    .ack_vec  (ack_vec_o),
    .as_block (as_block_o)
);

// File: tb/test_irq_avec_ctrl.sv
`timescale 1ns/1ps
module test_irq_avec_ctrl;
    localparam int N_INT = 8;
    localparam int REG_W = 8 + N_INT;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [7:1]       ext_irq = '0, lvl_en = '0;
    logic [N_INT-1:0] int_irq = '0;
    logic [2:0]       ipl;
    logic [1:0]       addr = '0;
    logic             wr = 1'b0;
    logic [REG_W-1:0] wdata = '0, rdata;
    logic             iack = 1'b0;
    logic [2:0]       iack_lvl = '0;
    logic             ack_vld, ack_auto, ack_ext, as_block;
    logic [7:0]       ack_vec;

    int checks = 0, errors = 0;
    bit done = 0;
    logic [31:0] rng = 32'h1234_5678;

    always #4 clk = ~clk;

    irq_avec_ctrl #(.N_INT(N_INT)) i_irq_avec_ctrl (
        .clk_i(clk), .rst_ni(rst_n), .ext_irq_i(ext_irq), .lvl_en_i(lvl_en),
        .int_irq_i(int_irq), .ipl_o(ipl), .reg_addr_i(addr), .reg_wr_i(wr),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata), .iack_i(iack),
        .iack_lvl_i(iack_lvl), .ack_vld_o(ack_vld), .ack_auto_o(ack_auto),
        .ack_ext_o(ack_ext), .ack_vec_o(ack_vec), .as_block_o(as_block)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] next_rnd();
        rng ^= rng << 13; rng ^= rng >> 17; rng ^= rng << 5;
        return rng;
    endfunction

    function automatic logic [2:0] exp_ipl(logic [7:1] e, logic [7:1] en,
                                           logic [N_INT-1:0] ii, logic [REG_W-1:0] m);
        logic [2:0] r = 0;
        for (int l = 1; l <= 7; l++) begin
            if (e[l] && en[l] && !m[l]) r = 3'(l);
            for (int k = 0; k < N_INT; k++)
                if (((k % 7) + 1) == l && ii[k] && !m[8+k]) r = 3'(l);
        end
        return r;
    endfunction

    task automatic reg_write(logic [1:0] a, logic [REG_W-1:0] d);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic reg_read(logic [1:0] a, string tag, logic [REG_W-1:0] exp);
        addr = a; #1;
        chk(tag, 32'(rdata), 32'(exp));
    endtask

    task automatic do_ack(logic [2:0] l, logic [7:0] av, logic [7:1] en, string tag);
        logic au;
        au = (l != 0) && av[l] && en[l];
        lvl_en = en; iack = 1'b1; iack_lvl = l;
        @(negedge clk);
        iack = 1'b0;
        chk({tag, " vld"}, 32'(ack_vld), 32'(l != 0));
        chk({tag, " auto"}, 32'(ack_auto), 32'(au));
        chk({tag, " ext"}, 32'(ack_ext), 32'((l != 0) && !au));
        chk({tag, " vec"}, 32'(ack_vec), au ? 32'(24 + l) : 32'd0);
        chk({tag, " blk R8"}, 32'(as_block), 32'(au && av[0]));
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [REG_W-1:0] m;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        reg_read(2'd1, "R1 mask reset", ~REG_W'(1));
        reg_read(2'd2, "R1 avec reset", '0);
        reg_read(2'd0, "R1 pend reset", '0);
        chk("R1 ipl reset", 32'(ipl), 0);
        chk("R1 no response", 32'(ack_vld), 0);

        // R2: masked sources still pend, ipl stays 0
        ext_irq = 7'h55; lvl_en = 7'h7F; int_irq = 8'hA5;
        @(negedge clk);
        reg_read(2'd0, "R2 pend while masked", {8'hA5, 7'h55, 1'b0});
        chk("R4 masked ipl", 32'(ipl), 0);

        // R3: pending write ignored
        reg_write(2'd0, '1);
        reg_read(2'd0, "R3 pend write ignored", {8'hA5, 7'h55, 1'b0});
        ext_irq = '0; int_irq = '0;
        reg_write(2'd0, '1);
        reg_read(2'd0, "R3 pend write zero", '0);

        // R5 mask readback with bit 0 forced low
        reg_write(2'd1, '1);
        reg_read(2'd1, "R5 mask readback", ~REG_W'(1));
        reg_write(2'd1, 16'h3C5B);
        reg_read(2'd1, "R5 mask readback2", 16'h3C5A);

        // R2/R4 sweep: all external patterns plus pseudo-random mixes
        for (int i = 0; i < 640; i++) begin
            logic [31:0] r = next_rnd();
            m = (i < 128) ? '0 : REG_W'(next_rnd());
            m[0] = 1'b0;
            reg_write(2'd1, m);
            ext_irq = (i < 128) ? 7'(i) : r[6:0];
            lvl_en  = (i < 128) ? 7'h7F : r[13:7];
            int_irq = (i < 128) ? '0 : r[21:14];
            @(negedge clk);
            reg_read(2'd0, "R2 pend sweep", {int_irq, ext_irq & lvl_en, 1'b0});
            chk("R4 ipl sweep", 32'(ipl), 32'(exp_ipl(ext_irq, lvl_en, int_irq, m)));
        end
        // internal-only walk
        reg_write(2'd1, '0);
        ext_irq = '0;
        for (int k = 0; k < N_INT; k++) begin
            int_irq = N_INT'(1) << k;
            @(negedge clk);
            chk("R4 internal level", 32'(ipl), 32'((k % 7) + 1));
        end
        int_irq = '0;

        // R6/R7/R8: every autovector register value, every level
        for (int av = 0; av < 256; av++) begin
            reg_write(2'd2, REG_W'(av));
            reg_read(2'd2, "R6 avec readback", REG_W'(av));
            for (int l = 1; l <= 7; l++) begin
                logic [31:0] r = next_rnd();
                do_ack(3'(l), 8'(av), (av < 128) ? 7'h7F : r[6:0], "R7 ack");
            end
        end

        // R9: response is a single pulse; level 0 gives nothing
        do_ack(3'd3, 8'hFF, 7'h7F, "R9 pulse");
        @(negedge clk);
        chk("R9 pulse ends", 32'(ack_vld), 0);
        do_ack(3'd0, 8'hFF, 7'h7F, "R9 level0");

        // R10: same-cycle write and acknowledge uses old value
        reg_write(2'd2, '0);
        addr = 2'd2; wdata = 16'h00FF; wr = 1'b1;
        lvl_en = 7'h7F; iack = 1'b1; iack_lvl = 3'd5;
        @(negedge clk);
        wr = 1'b0; iack = 1'b0;
        chk("R10 old value ext", 32'(ack_ext), 1);
        chk("R10 old value auto", 32'(ack_auto), 0);
        do_ack(3'd5, 8'hFF, 7'h7F, "R10 new value");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule